// File: doc/BRIEF.md
# Serial Register Port with Staged Update

This block is a serial-port slave that lets a host reach a byte-addressed register space through a four-signal or three-signal serial link. The serial clock, chip select and data line are brought into the system clock domain by synchronizers. Every transfer opens with a 16-bit instruction word that carries the direction, the byte count and a 12-bit start address. One to three data bytes follow.

Host writes do not reach the outputs directly. Each written byte lands in a staged copy. The whole staged set moves into the active copy in a single cycle when the host sets the update bit. A control byte chooses whether reads return the staged or the active values. A soft-reset bit returns the register contents to their defaults. A configuration bit chooses whether read data leaves on the shared data line or on a separate output pin. The active copy is presented on a flat output bus for the logic the port configures.

Top module: `spi_regport`

## Requirements
- R1: Each transfer starts with 16 instruction bits, MSB first, sampled on rising serial clock edges while chip select is low. Bit 15 = 1 means read and 0 means write, bits 14:13 hold the byte count minus one (0..2 for 1..3 bytes), bit 12 is ignored, and bits 11:0 give the start address.
- R2: A written byte changes only the staged copy. `active_regs` keeps its value until an update or a soft reset.
- R3: Writing a byte with bit 0 set to address 0x234 copies every staged byte, including the read-source bit, into the active copy. With bit 0 clear the write has no effect. Address 0x234 always reads 0.
- R4: A transfer moves exactly the counted number of bytes, MSB first, to addresses that count down from the start address. Any serial clocks after the last byte change nothing.
- R5: A read returns exactly the counted bytes, MSB first. Each bit is driven after the falling serial clock edge that precedes the rising edge on which the host samples it.
- R6: Bit 0 of address 0x004 (staged, then made active by an update) selects the read source. When the active bit is 1, reads of the user bytes and of 0x004 return staged contents. When it is 0, they return active contents.
- R7: Address 0x002 reads a fixed version code (default 0x03) and address 0x003 reads a fixed part code (default 0x52). Writes to either address are ignored.
- R8: Bit 7 of address 0x000 selects 4-wire mode. When it is 1, read data appears on `sdo_o` with `sdo_oe` high. When it is 0, read data appears on `sdio_o` with `sdio_oe` high. The other enable stays low, and the other bits of 0x000 read 0.
- R9: Writing a byte with bit 5 set to address 0x000 clears all staged and active user bytes and both copies of the read-source bit. Bit 5 reads back as 0, and bit 7 takes the written value.
- R10: Raising chip select ends the transfer at once. A data byte that has received fewer than 8 bits is discarded, and bytes already completed are kept.
- R11: Reads of addresses that hold no register (including 0x001 and 0x300) return 0.
- R12: After reset, `active_regs` is 0 and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data from host |
| sdio_o | output | 1 | Read data on shared line (3-wire) |
| sdio_oe | output | 1 | Drive enable for shared line |
| sdo_o | output | 1 | Read data on separate pin (4-wire) |
| sdo_oe | output | 1 | Drive enable for separate pin |
| active_regs | output | USER_BYTES*8 | Active copy of user bytes, byte i at bits 8i+7:8i |

## Verification
The hardest condition to reach is a staged copy that differs from the active copy while the read source is also switched. Only then does a read show which copy it came from. The stimulus reaches this state by writing one value, committing it with an update, and then overwriting the staged byte before the read. Random transfers interleave updates and read-source changes. A chip-select abort in the middle of a byte of a two-byte write checks the discard rule against a completed first byte.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int USER_BASE = 16,
  parameter int USER_BYTES = 16,
  parameter logic [7:0] VERSION_CODE = 8'h03,
  parameter logic [7:0] PART_CODE = 8'h52
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe,
  output logic sdo_o,
  output logic sdo_oe,
  output logic [USER_BYTES*8-1:0] active_regs
);
  localparam int IW = (USER_BYTES > 1) ? $clog2(USER_BYTES) : 1;
  localparam logic [11:0] UB = 12'(USER_BASE);
  localparam logic [11:0] NB = 12'(USER_BYTES);
  localparam logic [11:0] A_CFG = 12'h000;
  localparam logic [11:0] A_VER = 12'h002;
  localparam logic [11:0] A_PART = 12'h003;
  localparam logic [11:0] A_RB = 12'h004;
  localparam logic [11:0] A_UPD = 12'h234;

  typedef enum logic [1:0] {P_INS, P_DATA, P_DONE} phase_t;

  logic [2:0] sclk_p;
  logic [1:0] cs_p, din_p;
  logic rise, fall, cs_s, din_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p <= 2'b11;
      din_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      cs_p <= {cs_p[0], cs_n};
      din_p <= {din_p[0], sdio_i};
    end
  end

  assign rise = sclk_p[1] & ~sclk_p[2];
  assign fall = ~sclk_p[1] & sclk_p[2];
  assign cs_s = cs_p[1];
  assign din_s = din_p[1];

  phase_t phase;
  logic [3:0] bitcnt;
  logic [14:0] shreg;
  logic is_rd;
  logic [1:0] bytes_left;
  logic [11:0] cur_addr;
  logic [7:0] rd_byte;
  logic out_bit, oe_q;

  logic [7:0] stg [USER_BYTES];
  logic [7:0] act [USER_BYTES];
  logic rb_stg, rb_act, cfg_4w, upd_q, srst_q;
  logic [USER_BYTES*8-1:0] stg_flat;

  logic [11:0] ins_addr, nxt_addr, rd_addr, rd_off, wr_off;
  logic [7:0] rd_val, wbyte;
  logic wr_en;

  assign ins_addr = {shreg[10:0], din_s};
  assign nxt_addr = cur_addr - 12'd1;
  assign rd_addr = (phase == P_INS) ? ins_addr : nxt_addr;
  assign rd_off = rd_addr - UB;
  assign wr_off = cur_addr - UB;
  assign wbyte = {shreg[6:0], din_s};
  assign wr_en = !cs_s && rise && phase == P_DATA && !is_rd && bitcnt == 4'd7;

  always_comb begin
    rd_val = 8'h00;
    if (rd_addr == A_CFG) rd_val = {cfg_4w, 7'b0};
    else if (rd_addr == A_VER) rd_val = VERSION_CODE;
    else if (rd_addr == A_PART) rd_val = PART_CODE;
    else if (rd_addr == A_RB) rd_val = {7'b0, rb_act ? rb_stg : rb_act};
    else if (rd_off < NB) rd_val = rb_act ? stg[rd_off[IW-1:0]] : act[rd_off[IW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_INS;
      bitcnt <= '0;
      shreg <= '0;
      is_rd <= 1'b0;
      bytes_left <= '0;
      cur_addr <= '0;
      rd_byte <= '0;
      out_bit <= 1'b0;
      oe_q <= 1'b0;
    end else if (cs_s) begin
      phase <= P_INS;
      bitcnt <= '0;
      oe_q <= 1'b0;
    end else if (rise) begin
      case (phase)
        P_INS: begin
          shreg <= {shreg[13:0], din_s};
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd15) begin
            is_rd <= shreg[14];
            bytes_left <= shreg[13:12];
            cur_addr <= ins_addr;
            rd_byte <= rd_val;
            phase <= P_DATA;
            bitcnt <= '0;
          end
        end
        P_DATA: begin
          shreg <= {shreg[13:0], din_s};
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            bitcnt <= '0;
            cur_addr <= nxt_addr;
            rd_byte <= rd_val;
            if (bytes_left == 2'd0) phase <= P_DONE;
            else bytes_left <= bytes_left - 2'd1;
          end
        end
        default: ;
      endcase
    end else if (fall) begin
      if (phase == P_DATA && is_rd) begin
        out_bit <= rd_byte[~bitcnt[2:0]];
        oe_q <= 1'b1;
      end else begin
        oe_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < USER_BYTES; i++) begin
        stg[i] <= '0;
        act[i] <= '0;
      end
      rb_stg <= 1'b0;
      rb_act <= 1'b0;
      cfg_4w <= 1'b0;
      upd_q <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      upd_q <= wr_en && cur_addr == A_UPD && wbyte[0];
      srst_q <= wr_en && cur_addr == A_CFG && wbyte[5];
      if (srst_q) begin
        for (int i = 0; i < USER_BYTES; i++) begin
          stg[i] <= '0;
          act[i] <= '0;
        end
        rb_stg <= 1'b0;
        rb_act <= 1'b0;
      end else begin
        if (upd_q) begin
          for (int i = 0; i < USER_BYTES; i++) act[i] <= stg[i];
          rb_act <= rb_stg;
        end
        if (wr_en) begin
          if (cur_addr == A_CFG) cfg_4w <= wbyte[7];
          if (cur_addr == A_RB) rb_stg <= wbyte[0];
          if (wr_off < NB) stg[wr_off[IW-1:0]] <= wbyte;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < USER_BYTES; i++) begin
      active_regs[i*8 +: 8] = act[i];
      stg_flat[i*8 +: 8] = stg[i];
    end
  end

  assign sdo_o = cfg_4w & out_bit;
  assign sdo_oe = cfg_4w & oe_q;
  assign sdio_o = ~cfg_4w & out_bit;
  assign sdio_oe = ~cfg_4w & oe_q;

  // R3
  upd_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> active_regs == $past(stg_flat));
  // R3
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);
  // R2
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_q && !srst_q) |=> $stable(active_regs));
  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> active_regs == '0);
  // R8
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdio_oe && sdo_oe));
  // R10
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdio_oe && !sdo_oe);
endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;
  localparam int UBASE = 16;
  localparam int NB = 16;
  localparam logic [11:0] UB = 12'(UBASE);

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [NB*8-1:0] active_regs;

  always #5 clk = ~clk;

  spi_regport #(.USER_BASE(UBASE), .USER_BYTES(NB), .VERSION_CODE(8'h03), .PART_CODE(8'h52)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .active_regs(active_regs));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_stg [NB];
  logic [7:0] m_act [NB];
  logic m_rbs = 0, m_rba = 0, m_4w = 0;

  task automatic chk(input string req, input logic [127:0] a, input logic [127:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, a, e);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [11:0] a);
    logic [11:0] o;
    o = a - UB;
    if (a == 12'h000) return {m_4w, 7'b0};
    if (a == 12'h002) return 8'h03;
    if (a == 12'h003) return 8'h52;
    if (a == 12'h004) return {7'b0, m_rba ? m_rbs : m_rba};
    if (o < 12'(NB)) return m_rba ? m_stg[o[3:0]] : m_act[o[3:0]];
    return 8'h00;
  endfunction

  function automatic logic [127:0] exp_act();
    logic [127:0] v;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = m_act[i];
    return v;
  endfunction

  task automatic model_wr(input logic [11:0] a, input logic [7:0] b);
    logic [11:0] o;
    o = a - UB;
    if (a == 12'h000) begin
      m_4w = b[7];
      if (b[5]) begin
        for (int i = 0; i < NB; i++) begin m_stg[i] = 0; m_act[i] = 0; end
        m_rbs = 0; m_rba = 0;
      end
    end else if (a == 12'h004) m_rbs = b[0];
    else if (a == 12'h234) begin
      if (b[0]) begin
        for (int i = 0; i < NB; i++) m_act[i] = m_stg[i];
        m_rba = m_rbs;
      end
    end else if (o < 12'(NB)) m_stg[o[3:0]] = b;
  endtask

  task automatic xfer(input logic rd, input int cnt, input logic [11:0] a,
                      input logic [23:0] wd, input int nbits, output logic [23:0] rv);
    logic [15:0] ins;
    int tot, bad;
    logic b;
    ins = {rd, 2'(cnt - 1), 1'b0, a};
    tot = (nbits > 0) ? nbits : 16 + 8 * cnt;
    rv = 0; bad = 0;
    @(negedge clk); cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < tot; i++) begin
      if (i < 16) b = ins[15 - i];
      else if (i < 16 + 8 * cnt) b = wd[8 * cnt - 1 - (i - 16)];
      else b = 1'b1;
      sclk = 0; sdio_i = b;
      repeat (8) @(negedge clk);
      if (rd && i >= 16 && i < 16 + 8 * cnt) begin
        rv = {rv[22:0], m_4w ? sdo_o : sdio_o};
        if (m_4w ? (!sdo_oe || sdio_oe) : (!sdio_oe || sdo_oe)) bad++;
      end
      sclk = 1;
      repeat (8) @(negedge clk);
    end
    sclk = 0;
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (8) @(negedge clk);
    // R8: only the selected pin drives during read data
    if (rd) chk("R8 enables", 128'(bad), 128'd0);
  endtask

  task automatic wr(input logic [11:0] a, input int cnt, input logic [23:0] wd);
    logic [23:0] dummy;
    xfer(1'b0, cnt, a, wd, 0, dummy);
    for (int k = 0; k < cnt; k++) model_wr(a - 12'(k), wd[8 * (cnt - 1 - k) +: 8]);
  endtask

  task automatic rd_chk(input logic [11:0] a, input int cnt, input string req);
    logic [23:0] got, e;
    e = 0;
    for (int k = 0; k < cnt; k++) e = {e[15:0], exp_rd(a - 12'(k))};
    xfer(1'b1, cnt, a, 24'h0, 0, got);
    chk(req, 128'(got), 128'(e));
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] dummy;
    logic [11:0] ra;
    int op, cnt;
    for (int i = 0; i < NB; i++) begin m_stg[i] = 0; m_act[i] = 0; end
    void'($urandom(32'd20240611));
    repeat (10) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R12
    chk("R12 active", 128'(active_regs), 128'd0);
    chk("R12 enables", 128'({sdio_oe, sdo_oe}), 128'd0);

    // R1 R2: write lands only in staged copy
    wr(UB, 1, 24'h5A);
    chk("R2 active after write", 128'(active_regs), exp_act());
    rd_chk(UB, 1, "R2 read active");
    // R3: update with bit0 clear then set
    wr(12'h234, 1, 24'h00);
    chk("R3 no update", 128'(active_regs), exp_act());
    wr(12'h234, 1, 24'h01);
    chk("R3 update", 128'(active_regs), exp_act());
    rd_chk(12'h234, 1, "R3 reads zero");
    rd_chk(UB, 1, "R3 read committed");

    // R4 R5: multi-byte descending
    wr(UB + 12'd15, 3, 24'h112233);
    wr(12'h234, 1, 24'h01);
    rd_chk(UB + 12'd15, 3, "R4 three bytes");
    rd_chk(UB + 12'd14, 2, "R5 two bytes");
    // R4: extra clocks after last byte ignored
    xfer(1'b0, 1, UB + 12'd5, 24'hC3, 32, dummy);
    model_wr(UB + 12'd5, 8'hC3);
    wr(12'h234, 1, 24'h01);
    rd_chk(UB + 12'd5, 2, "R4 extra bits");

    // R6: read source select
    wr(UB + 12'd3, 1, 24'h77);
    wr(12'h004, 1, 24'h01);
    wr(12'h234, 1, 24'h01);
    wr(UB + 12'd3, 1, 24'h88);
    rd_chk(UB + 12'd3, 1, "R6 staged read");
    rd_chk(12'h004, 1, "R6 select reads back");
    chk("R6 active keeps old", 128'(active_regs), exp_act());
    wr(12'h004, 1, 24'h00);
    wr(12'h234, 1, 24'h01);
    rd_chk(UB + 12'd3, 1, "R6 active read");

    // R7
    rd_chk(12'h002, 2, "R7 version");
    wr(12'h003, 1, 24'hFF);
    rd_chk(12'h003, 1, "R7 part");
    // R11
    rd_chk(12'h300, 3, "R11 unmapped");
    rd_chk(12'h001, 1, "R11 gap");

    // R8: 4-wire mode
    wr(12'h000, 1, 24'h80);
    rd_chk(UB + 12'd15, 1, "R8 four wire data");
    rd_chk(12'h000, 1, "R8 config read");

    // R10: aborts
    xfer(1'b0, 2, UB + 12'd9, 24'hABCD, 16 + 8 + 3, dummy);
    model_wr(UB + 12'd9, 8'hAB);
    xfer(1'b0, 1, UB + 12'd7, 24'hEE, 20, dummy);
    wr(12'h234, 1, 24'h01);
    rd_chk(UB + 12'd9, 3, "R10 abort");
    wr(12'h000, 1, 24'h00);

    // random mix
    for (int it = 0; it < 80; it++) begin
      op = $urandom % 11;
      cnt = 1 + ($urandom % 3);
      if (op <= 4) wr(UB + 12'(2 + $urandom % 14), cnt, 24'($urandom));
      else if (op <= 7) begin
        case ($urandom % 4)
          0: ra = 12'($urandom % 6);
          1: ra = 12'h234;
          2: ra = 12'h300 + 12'($urandom % 8);
          default: ra = UB + 12'($urandom % NB);
        endcase
        rd_chk(ra, cnt, "R5 random read");
      end else if (op == 8) wr(12'h234, 1, 24'($urandom % 4));
      else if (op == 9) wr(12'h004, 1, 24'($urandom % 256));
      else wr(12'h000, 1, {16'h0, 1'($urandom % 2), 7'b0});
      chk("R2 random active", 128'(active_regs), exp_act());
    end

    // R9: soft reset
    wr(12'h000, 1, 24'h20);
    chk("R9 active cleared", 128'(active_regs), 128'd0);
    rd_chk(12'h000, 1, "R9 bit clears");
    rd_chk(UB + 12'd15, 3, "R9 staged cleared");
    rd_chk(12'h004, 1, "R9 select cleared");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule